// File: doc/BRIEF.md
# Greedy Nearest-Neighbour Vector Sequencer

This block takes an N-by-N table of transition costs between N test vectors and produces a visiting order for them, so that the cost of stepping from one vector to the next stays low. The entry at row i, column j is the cost of applying vector j immediately after vector i. A host fills the table through a simple write port, then pulses `start`. The engine walks the table greedily: it always moves from the current vector to the cheapest vector that has not yet been used, and streams each chosen vector index out with a valid strobe and a last flag.

The walk can begin in one of two ways. In automatic mode the engine first searches the entire table for its cheapest off-diagonal entry and emits that entry's row index, then its column index. In seed mode the host names the first vector, which lets alternative orderings be produced from the same table. Each search reads one table entry per clock, so a run takes on the order of N squared cycles. When the final index leaves, the sum of all edge costs taken is presented together with a one-cycle completion pulse.

Top module: `vec_seq_greedy`

## Requirements
- R1: After reset `out_valid`, `out_last`, `done` and `busy` are 0 and `path_cost` is 0.
- R2: A write with `wr_en` high stores `wr_data` as the cost of applying vector `wr_col` right after vector `wr_row`; the engine reads these stored costs on its next run.
- R3: With `seed_mode` = 0 the first two emitted indices are the row and then the column of the smallest off-diagonal entry; on equal costs the entry with the lowest row, then lowest column, wins.
- R4: A run emits exactly N indices, each vector exactly once, and `out_last` is 1 only with the N-th index.
- R5: Every index after the opening one (seed mode) or two (automatic mode) is the unvisited vector with the lowest cost in the row of the previously emitted vector; on equal costs the lowest index wins.
- R6: With `seed_mode` = 1 the first emitted index equals `seed_idx`.
- R7: Diagonal entries (row equals column) never influence the choice, whatever their value.
- R8: `done` is high for exactly one cycle, together with the last index, and `path_cost` then equals the sum of the costs of the N-1 edges taken, held without overflow in W+log2(N) bits.
- R9: A `start` pulse seen while `busy` is 1 has no effect on the run in progress.
- R10: Counting the edge that samples `start` as cycle 1, in seed mode the k-th index (k from 1) appears after edge 1+(k-1)·N; in automatic mode the first index appears after edge 1+N·N, the second one cycle later, and each further one N cycles after its predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Cost table write strobe |
| wr_row | input | $clog2(N) | Row (preceding vector) of the write |
| wr_col | input | $clog2(N) | Column (following vector) of the write |
| wr_data | input | W | Cost value to store |
| start | input | 1 | Begin a run (ignored while busy) |
| seed_mode | input | 1 | 1 = start from `seed_idx`, 0 = start from global minimum |
| seed_idx | input | $clog2(N) | Starting vector in seed mode |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | `out_idx` carries the next vector of the order |
| out_idx | output | $clog2(N) | Emitted vector index |
| out_last | output | 1 | Marks the final emitted index |
| path_cost | output | W+$clog2(N) | Accumulated cost of edges taken |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Every result has a fixed due cycle measured from the edge that samples `start`: in seed mode the first index is due on that same edge and the others every N cycles; in automatic mode the first index is due N·N cycles later, the second on the next edge, then every N cycles, and `done` with the final cost coincides with the last index. The bench counts edges from the start edge, samples one nanosecond after each rising edge, and checks both the value and the edge number of every emission against these formulas. A stray `start` raised mid-run must leave both the sequence and its timing untouched.

// File: rtl/vec_seq_greedy.sv
module vec_seq_greedy #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(N)-1:0]        wr_row,
  input  logic [$clog2(N)-1:0]        wr_col,
  input  logic [W-1:0]                wr_data,
  input  logic                        start,
  input  logic                        seed_mode,
  input  logic [$clog2(N)-1:0]        seed_idx,
  output logic                        busy,
  output logic                        out_valid,
  output logic [$clog2(N)-1:0]        out_idx,
  output logic                        out_last,
  output logic [W+$clog2(N)-1:0]      path_cost,
  output logic                        done
);
  localparam int IW = $clog2(N);
  localparam int AW = $clog2(N*N);
  localparam int CW = W + IW;
  localparam int KW = $clog2(N+1);

  typedef enum logic [1:0] {IDLE, GSCAN, EMIT2, RSCAN} st_t;

  st_t            st;
  logic [W-1:0]   mem [N*N];
  logic [IW-1:0]  sr, sc, br, bc;
  logic [W-1:0]   bw;
  logic           have;
  logic [N-1:0]   vis;
  logic [KW-1:0]  cnt;

  function automatic logic [N-1:0] bit_of(input logic [IW-1:0] i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  always_ff @(posedge clk)
    if (wr_en) mem[AW'(wr_row) * AW'(N) + AW'(wr_col)] <= wr_data;

  logic [W-1:0]  ew;
  logic          cand, take, end_col, end_all;
  logic [W-1:0]  nb_w;
  logic [IW-1:0] nb_r, nb_c;

  assign ew      = mem[AW'(sr) * AW'(N) + AW'(sc)];
  assign cand    = (st == GSCAN) ? (sr != sc) : !vis[sc];
  assign take    = cand && (!have || ew < bw);
  assign nb_w    = take ? ew : bw;
  assign nb_r    = take ? sr : br;
  assign nb_c    = take ? sc : bc;
  assign end_col = sc == IW'(N-1);
  assign end_all = end_col && sr == IW'(N-1);
  assign busy    = st != IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; sr <= '0; sc <= '0; br <= '0; bc <= '0; bw <= '0;
      have <= 1'b0; vis <= '0; cnt <= '0; path_cost <= '0;
      out_valid <= 1'b0; out_idx <= '0; out_last <= 1'b0; done <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      case (st)
        IDLE: if (start) begin
          path_cost <= '0;
          have      <= 1'b0;
          sc        <= '0;
          if (seed_mode) begin
            out_valid <= 1'b1;
            out_idx   <= seed_idx;
            vis       <= bit_of(seed_idx);
            sr        <= seed_idx;
            cnt       <= KW'(1);
            st        <= RSCAN;
          end else begin
            vis <= '0;
            sr  <= '0;
            st  <= GSCAN;
          end
        end
        GSCAN: begin
          have <= have | take;
          bw <= nb_w; br <= nb_r; bc <= nb_c;
          if (end_all) begin
            out_valid <= 1'b1;
            out_idx   <= nb_r;
            vis       <= bit_of(nb_r);
            st        <= EMIT2;
          end else begin
            sc <= end_col ? '0 : sc + 1'b1;
            sr <= end_col ? sr + 1'b1 : sr;
          end
        end
        EMIT2: begin
          out_valid <= 1'b1;
          out_idx   <= bc;
          path_cost <= path_cost + CW'(bw);
          sr        <= bc;
          sc        <= '0;
          have      <= 1'b0;
          cnt       <= KW'(2);
          if (N == 2) begin
            out_last <= 1'b1; done <= 1'b1; vis <= '0; st <= IDLE;
          end else begin
            vis <= vis | bit_of(bc);
            st  <= RSCAN;
          end
        end
        RSCAN: begin
          if (end_col) begin
            out_valid <= 1'b1;
            out_idx   <= nb_c;
            path_cost <= path_cost + CW'(nb_w);
            sr        <= nb_c;
            sc        <= '0;
            have      <= 1'b0;
            cnt       <= cnt + 1'b1;
            if (cnt == KW'(N-1)) begin
              out_last <= 1'b1; done <= 1'b1; vis <= '0; st <= IDLE;
            end else begin
              vis <= vis | bit_of(nb_c);
            end
          end else begin
            have <= have | take;
            bw <= nb_w; bc <= nb_c;
            sc <= sc + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r8_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && out_last);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_fresh_index: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> $countones(vis) == $countones($past(vis)) + 1);
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid || out_last);
  a_r8_cost_grows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> path_cost >= $past(path_cost));
endmodule

// File: tb/test_vec_seq_greedy.sv
module test_vec_seq_greedy;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, seed_mode = 1'b0;
  logic [1:0] wr_row = '0, wr_col = '0, seed_idx = '0;
  logic [W-1:0] wr_data = '0;
  logic busy, out_valid, out_last, done;
  logic [1:0] out_idx;
  logic [9:0] path_cost;

  int checks = 0, fails = 0;

  vec_seq_greedy #(.N(N), .W(W)) i_vec_seq_greedy (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .start(start), .seed_mode(seed_mode), .seed_idx(seed_idx),
    .busy(busy), .out_valid(out_valid), .out_idx(out_idx), .out_last(out_last),
    .path_cost(path_cost), .done(done));

  always #2 clk = ~clk;

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // {sel[1:0], mode, seed[1:0], o0,o1,o2,o3 (2b each), cost[9:0]}
  localparam logic [22:0] CASES [7] = '{
    {2'd0, 1'b0, 2'd0, 2'd2, 2'd1, 2'd0, 2'd3, 10'd7},
    {2'd0, 1'b1, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1, 10'd5},
    {2'd0, 1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0, 10'd7},
    {2'd0, 1'b1, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 10'd12},
    {2'd1, 1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 10'd15},
    {2'd1, 1'b1, 2'd2, 2'd2, 2'd0, 2'd1, 2'd3, 10'd15},
    {2'd2, 1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 10'd765}
  };

  function automatic logic [7:0] cost_of(input int sel, input int i, input int j);
    logic [7:0] a [16] = '{8'd0, 8'd5, 8'd9, 8'd2,
                           8'd4, 8'd0, 8'd3, 8'd8,
                           8'd7, 8'd1, 8'd0, 8'd6,
                           8'd3, 8'd9, 8'd2, 8'd0};
    if (sel == 0) return a[i*4+j];
    if (sel == 1) return (i == j) ? 8'd0 : 8'd5;
    return (i == j) ? 8'd0 : 8'd255;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int sel);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'(i); wr_col = 2'(j); wr_data = cost_of(sel, i, j);
      end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic run(input logic [22:0] c, input int inject);
    int ord [4];
    int due [4];
    int seen = 0;
    int dones = 0;
    ord[0] = int'(c[17:16]); ord[1] = int'(c[15:14]);
    ord[2] = int'(c[13:12]); ord[3] = int'(c[11:10]);
    for (int k = 0; k < N; k++)
      due[k] = c[20] ? 1 + k*N : (k == 0 ? 1 + N*N : 2 + N*N + (k-1)*N);
    @(negedge clk);
    start = 1'b1; seed_mode = c[20]; seed_idx = c[19:18];
    for (int cyc = 1; cyc <= 40; cyc++) begin
      @(posedge clk); #1;
      if (cyc == 1) start = 1'b0;
      if (cyc == inject) begin start = 1'b1; seed_mode = 1'b1; seed_idx = 2'd2; end
      if (cyc == inject + 1) start = 1'b0;
      if (done) dones++;
      if (out_valid) begin
        if (seen < N) begin
          check(out_idx == 2'(ord[seen]), seen < 2 ? "R3/R6 opening index" : "R5 next index",
                int'(out_idx), ord[seen]);
          check(cyc == due[seen], "R10 emission cycle", cyc, due[seen]);
          check(out_last == (seen == N-1), "R4 last flag", int'(out_last), int'(seen == N-1));
        end
        seen++;
        if (out_last) begin
          check(done == 1'b1, "R8 done with last", int'(done), 1);
          check(path_cost == c[9:0], "R8 path cost", int'(path_cost), int'(c[9:0]));
        end
      end
    end
    check(seen == N, "R4 index count", seen, N);
    check(dones == 1, "R8 done pulses", dones, 1);
    check(busy == 1'b0, "R9 idle after run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(path_cost == 10'd0, "R1 path_cost", int'(path_cost), 0);

    for (int t = 0; t < 7; t++) begin
      if (t == 0 || CASES[t][22:21] != CASES[t-1][22:21]) load(int'(CASES[t][22:21]));
      run(CASES[t], 0);
    end

    // R9: stray start mid-run, seed-mode run and automatic run
    load(0);
    run(CASES[1], 4);
    run(CASES[0], 7);

    // R2 / R7: rewrite one entry, then diagonal made tiny must not matter
    @(negedge clk); wr_en = 1'b1; wr_row = 2'd0; wr_col = 2'd1; wr_data = 8'd0;
    @(negedge clk); wr_en = 1'b1; wr_row = 2'd3; wr_col = 2'd3; wr_data = 8'd0;
    @(negedge clk); wr_en = 1'b0;
    // new global min (0,1)=0; then row1: 2(3),3(8) -> 2; row2: 3 -> 6; cost 9 (R2, R7)
    run({2'd0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 10'd9}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule